// File: doc/BRIEF.md
# SPI Status and Error Interrupt Aggregator

This block turns the internal conditions of an SPI controller into two interrupt lines and two DMA request lines. Each cycle it receives the fill levels of the receive and transmit FIFOs, four watermark thresholds, word-count reload and decrement strobes for each direction, and the controller's mode and enable settings. From these it derives hysteresis watermark flags, burst start and finish events, a mode-fault error and a transmit-underflow error. A status word makes all of these visible to software.

The two watermark flags show the current hysteresis state. The four burst events and the two errors are sticky: each stays set until software writes a 1 to its clear strobe. Every source has its own mask bit. The unmasked status sources are ORed onto one status IRQ line and the unmasked error sources onto one error IRQ line. A channel that runs in DMA mode drives its urgent watermark condition out as a DMA request. That condition then no longer reaches the status IRQ.

Top module: `spi_irq_aggr`

## Requirements
- R1: Receive urgent flag (status bit 0) sets one cycle after rx_level is strictly above rx_urg_wm. It clears one cycle after rx_level is at or below rx_reg_wm. In between, it holds its value.
- R2: Transmit urgent flag (status bit 1) sets one cycle after tx_level is strictly below tx_urg_wm. It clears one cycle after tx_level is at or above tx_reg_wm. In between, it holds its value.
- R3: When rx_dma or tx_dma is 1, that channel's urgent flag drives rx_dma_req or tx_dma_req and does not contribute to irq_status. When the DMA bit is 0, the DMA request is 0.
- R4: A load pulse on a direction's word counter sets the start event one cycle later. Transmit start is status bit 2 and receive start is status bit 3.
- R5: A decrement strobe that takes a loaded counter from 1 to 0 sets the finish event one cycle later. Transmit finish is status bit 4 and receive finish is status bit 5. Earlier decrements do not set it.
- R6: In master mode, a low on ss_n_in sets mode fault (status bit 6) three cycles later, after a two-flop synchronizer. In slave mode a low ss_n_in raises nothing.
- R7: A xfer_start pulse while tx_level is 0 sets transmit underflow (status bit 7) one cycle later. It is never set when master_mode and tx_initiate are both 1.
- R8: Underflow needs tx_en = 1. Mode fault needs rx_en or tx_en to be 1. With the relevant channels disabled, these errors are ignored.
- R9: mask bit n = 1 blocks status bit n. irq_status is the OR of unmasked bits 0 to 5. irq_error is the OR of unmasked bits 6 and 7.
- R10: A 1 on status_clr bit n clears sticky bit n (bits 2 to 7) on the next edge, unless a new event arrives in the same cycle. Bits 0 and 1 ignore status_clr.
- R11: A decrement strobe while the counter is already 0 has no effect and raises no second finish event.
- R12: Under synchronous active-high reset, the status word is 0 and irq_status, irq_error and both DMA requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_urg_wm | input | LVL_W | Receive urgent threshold |
| rx_reg_wm | input | LVL_W | Receive regular (release) threshold |
| tx_urg_wm | input | LVL_W | Transmit urgent threshold |
| tx_reg_wm | input | LVL_W | Transmit regular (release) threshold |
| rx_reload | input | CNT_W | Receive word counter reload value |
| tx_reload | input | CNT_W | Transmit word counter reload value |
| rx_load | input | 1 | Receive counter load pulse |
| tx_load | input | 1 | Transmit counter load pulse |
| rx_dec | input | 1 | Receive word-done decrement strobe |
| tx_dec | input | 1 | Transmit word-done decrement strobe |
| master_mode | input | 1 | 1 = master, 0 = slave |
| tx_initiate | input | 1 | Master transfers are started by transmit |
| ss_n_in | input | 1 | Slave-select input, active low |
| xfer_start | input | 1 | New transfer start strobe |
| rx_en | input | 1 | Receive channel enable |
| tx_en | input | 1 | Transmit channel enable |
| rx_dma | input | 1 | Receive channel in DMA mode |
| tx_dma | input | 1 | Transmit channel in DMA mode |
| mask | input | 8 | Per-source mask, 1 blocks |
| status_clr | input | 8 | Write-one-to-clear strobes |
| status | output | 8 | Status word |
| irq_status | output | 1 | Aggregated status interrupt |
| irq_error | output | 1 | Aggregated error interrupt |
| rx_dma_req | output | 1 | Receive DMA data request |
| tx_dma_req | output | 1 | Transmit DMA data request |

## Verification
The hysteresis checks assume the watermarks are ordered sensibly. The receive regular threshold is below the urgent one, and the transmit regular threshold is above its urgent one, so the set and clear regions never overlap. The bench keeps these values fixed while it moves the levels. The counter checks assume a load and a decrement do not arrive in the same cycle as a finish, and the stimulus always separates them. The stimulus also returns ss_n_in high and waits out the synchronizer before it clears any sticky bits, so that no error re-arms.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int NSRC  = 8;
    localparam int B_RXU = 0;
    localparam int B_TXU = 1;
    localparam int B_TXS = 2;
    localparam int B_RXS = 3;
    localparam int B_TXF = 4;
    localparam int B_RXF = 5;
    localparam int B_MF  = 6;
    localparam int B_TUR = 7;

    typedef struct packed {
        logic tur;
        logic mf;
        logic rx_fin;
        logic tx_fin;
        logic rx_start;
        logic tx_start;
    } evt_t;

    function automatic logic hyst_next(input logic cur, input logic set_c, input logic clr_c);
        if (set_c)      return 1'b1;
        else if (clr_c) return 1'b0;
        else            return cur;
    endfunction
endpackage

// File: rtl/spi_wm_hyst.sv
module spi_wm_hyst #(
    parameter int LVL_W = 5,
    parameter bit DRAIN = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] urg_wm,
    input  logic [LVL_W-1:0] reg_wm,
    output logic             urgent
);
    import spi_irq_pkg::*;

    logic breach, relax;

    generate
        if (DRAIN) begin : g_drain
            assign breach = level < urg_wm;
            assign relax  = level >= reg_wm;
        end else begin : g_fill
            assign breach = level > urg_wm;
            assign relax  = level <= reg_wm;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) urgent <= 1'b0;
        else     urgent <= hyst_next(urgent, breach, relax);
    end

    // R1 R2
    rise_on_cross_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(urgent) |-> (DRAIN ? ($past(level) < $past(urg_wm)) : ($past(level) > $past(urg_wm))));
    // R1 R2
    fall_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(urgent) |-> (DRAIN ? ($past(level) >= $past(reg_wm)) : ($past(level) <= $past(reg_wm))));
endmodule

// File: rtl/spi_word_cnt.sv
module spi_word_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] reload,
    input  logic             load,
    input  logic             dec,
    output logic             start_evt,
    output logic             fin_evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    assign start_evt = load;
    assign fin_evt   = !load && dec && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= reload;
        else if (dec && (cnt != '0))
            cnt <= cnt - ONE;
    end

    // R5
    finish_reaches_zero_chk: assert property (@(posedge clk) disable iff (rst)
        fin_evt |=> (cnt == '0));
    // R11
    zero_dec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && (cnt == '0)) |=> ((cnt == '0) && !fin_evt || load));
endmodule

// File: rtl/spi_err_det.sv
module spi_err_det #(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             master_mode,
    input  logic             tx_initiate,
    input  logic             ss_n_in,
    input  logic             xfer_start,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             rx_en,
    input  logic             tx_en,
    output logic             mf_evt,
    output logic             tur_evt
);
    logic ss_s1, ss_s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            ss_s1 <= 1'b1;
            ss_s2 <= 1'b1;
        end else begin
            ss_s1 <= ss_n_in;
            ss_s2 <= ss_s1;
        end
    end

    assign mf_evt  = master_mode && !ss_s2 && (rx_en || tx_en);
    assign tur_evt = xfer_start && tx_en && (tx_level == '0) && !(master_mode && tx_initiate);

    // R6
    mf_needs_low_ss_chk: assert property (@(posedge clk) disable iff (rst)
        mf_evt |-> ($past(ss_n_in, 2) == 1'b0));
endmodule

// File: rtl/spi_irq_aggr.sv
module spi_irq_aggr #(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 16,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_urg_wm,
    input  logic [LVL_W-1:0] rx_reg_wm,
    input  logic [LVL_W-1:0] tx_urg_wm,
    input  logic [LVL_W-1:0] tx_reg_wm,
    input  logic [CNT_W-1:0] rx_reload,
    input  logic [CNT_W-1:0] tx_reload,
    input  logic             rx_load,
    input  logic             tx_load,
    input  logic             rx_dec,
    input  logic             tx_dec,
    input  logic             master_mode,
    input  logic             tx_initiate,
    input  logic             ss_n_in,
    input  logic             xfer_start,
    input  logic             rx_en,
    input  logic             tx_en,
    input  logic             rx_dma,
    input  logic             tx_dma,
    input  logic [7:0]       mask,
    input  logic [7:0]       status_clr,
    output logic [7:0]       status,
    output logic             irq_status,
    output logic             irq_error,
    output logic             rx_dma_req,
    output logic             tx_dma_req
);
    import spi_irq_pkg::*;

    localparam int NSTICKY = NSRC - 2;

    logic rx_urg, tx_urg;
    evt_t ev;
    logic [NSTICKY-1:0] sticky_q;
    logic [NSTICKY-1:0] ev_vec;
    logic [5:0] stat_src;

    spi_wm_hyst #(.LVL_W(LVL_W), .DRAIN(1'b0)) u_rx_wm (
        .clk(clk), .rst(rst), .level(rx_level),
        .urg_wm(rx_urg_wm), .reg_wm(rx_reg_wm), .urgent(rx_urg));

    spi_wm_hyst #(.LVL_W(LVL_W), .DRAIN(1'b1)) u_tx_wm (
        .clk(clk), .rst(rst), .level(tx_level),
        .urg_wm(tx_urg_wm), .reg_wm(tx_reg_wm), .urgent(tx_urg));

    spi_word_cnt #(.CNT_W(CNT_W)) u_tx_cnt (
        .clk(clk), .rst(rst), .reload(tx_reload), .load(tx_load),
        .dec(tx_dec), .start_evt(ev.tx_start), .fin_evt(ev.tx_fin));

    spi_word_cnt #(.CNT_W(CNT_W)) u_rx_cnt (
        .clk(clk), .rst(rst), .reload(rx_reload), .load(rx_load),
        .dec(rx_dec), .start_evt(ev.rx_start), .fin_evt(ev.rx_fin));

    spi_err_det #(.LVL_W(LVL_W)) u_err (
        .clk(clk), .rst(rst), .master_mode(master_mode), .tx_initiate(tx_initiate),
        .ss_n_in(ss_n_in), .xfer_start(xfer_start), .tx_level(tx_level),
        .rx_en(rx_en), .tx_en(tx_en), .mf_evt(ev.mf), .tur_evt(ev.tur));

    assign ev_vec = ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= '0;
        end else begin
            for (int i = 0; i < NSTICKY; i++)
                sticky_q[i] <= (sticky_q[i] && !status_clr[i+2]) || ev_vec[i];
        end
    end

    assign status   = {sticky_q, tx_urg, rx_urg};
    assign stat_src = {status[B_RXF:B_TXS], tx_urg && !tx_dma, rx_urg && !rx_dma};

    assign irq_status = |(stat_src & ~mask[5:0]);
    assign irq_error  = |(status[B_TUR:B_MF] & ~mask[B_TUR:B_MF]);
    assign rx_dma_req = rx_urg && rx_dma;
    assign tx_dma_req = tx_urg && tx_dma;

    // R9
    irq_err_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_error |-> (status[B_MF] || status[B_TUR]));
    // R7
    no_tur_master_init_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[B_TUR]) |-> !($past(master_mode) && $past(tx_initiate)));
    // R10
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (status_clr[B_TXS] && !tx_load) |=> !status[B_TXS]);
    // R10
    wm_not_clearable_chk: assert property (@(posedge clk) disable iff (rst)
        (status_clr[B_RXU] && status_clr[B_TXU] && status[B_RXU] && (rx_level > rx_urg_wm)) |=> status[B_RXU]);
    // R3
    dma_req_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_dma_req || tx_dma_req) |-> (rx_dma || tx_dma));
endmodule

// File: tb/spi_irq_aggr_tb.sv
module spi_irq_aggr_tb;
    localparam int PERIOD = 10;
    localparam int LVL_W  = 5;
    localparam int CNT_W  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [LVL_W-1:0] rx_level = '0, tx_level = 5'd16;
    logic [LVL_W-1:0] rx_urg_wm = 5'd12, rx_reg_wm = 5'd4;
    logic [LVL_W-1:0] tx_urg_wm = 5'd4, tx_reg_wm = 5'd10;
    logic [CNT_W-1:0] rx_reload = '0, tx_reload = '0;
    logic rx_load = 0, tx_load = 0, rx_dec = 0, tx_dec = 0;
    logic master_mode = 0, tx_initiate = 0, ss_n_in = 1, xfer_start = 0;
    logic rx_en = 0, tx_en = 0, rx_dma = 0, tx_dma = 0;
    logic [7:0] mask = 8'hFF, status_clr = 8'h00;
    logic [7:0] status;
    logic irq_status, irq_error, rx_dma_req, tx_dma_req;

    int n_chk = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    spi_irq_aggr #(.FIFO_DEPTH(16), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
        .rx_urg_wm(rx_urg_wm), .rx_reg_wm(rx_reg_wm), .tx_urg_wm(tx_urg_wm),
        .tx_reg_wm(tx_reg_wm), .rx_reload(rx_reload), .tx_reload(tx_reload),
        .rx_load(rx_load), .tx_load(tx_load), .rx_dec(rx_dec), .tx_dec(tx_dec),
        .master_mode(master_mode), .tx_initiate(tx_initiate), .ss_n_in(ss_n_in),
        .xfer_start(xfer_start), .rx_en(rx_en), .tx_en(tx_en), .rx_dma(rx_dma),
        .tx_dma(tx_dma), .mask(mask), .status_clr(status_clr), .status(status),
        .irq_status(irq_status), .irq_error(irq_error),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req));

    // {level[5:1], expected receive urgent flag[0]}; urgent 12, regular 4
    localparam logic [5:0] RXV [10] = '{
        {5'd3, 1'b0}, {5'd10, 1'b0}, {5'd12, 1'b0}, {5'd13, 1'b1}, {5'd8, 1'b1},
        {5'd5, 1'b1}, {5'd4, 1'b0}, {5'd9, 1'b0}, {5'd14, 1'b1}, {5'd0, 1'b0}};

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        status_clr = 8'hFF;
        tick();
        status_clr = 8'h00;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        // R12 reset state
        chk("R12 status", status, 8'h00);
        chk("R12 irqs", {4'h0, irq_status, irq_error, rx_dma_req, tx_dma_req}, 8'h00);
        rst = 1'b0;

        // R1 table walk
        foreach (RXV[i]) begin
            rx_level = RXV[i][5:1];
            tick();
            chk($sformatf("R1 step %0d", i), {7'h0, status[0]}, {7'h0, RXV[i][0]});
        end

        // R2 transmit hysteresis
        tx_level = 5'd3;  tick(); chk("R2 drain set", {7'h0, status[1]}, 8'h01);
        tx_level = 5'd8;  tick(); chk("R2 hold", {7'h0, status[1]}, 8'h01);
        // R10 watermark bits ignore clear
        status_clr = 8'h03; tick(); status_clr = 8'h00;
        chk("R10 wm not clearable", {7'h0, status[1]}, 8'h01);
        // R3 DMA routing
        mask = 8'h00;
        tx_dma = 1'b1; #1;
        chk("R3 dma req", {6'h0, tx_dma_req, irq_status}, 8'h02);
        tx_dma = 1'b0; #1;
        chk("R3 irq path", {6'h0, tx_dma_req, irq_status}, 8'h01);
        mask = 8'hFF;
        tx_level = 5'd10; tick(); chk("R2 release", {7'h0, status[1]}, 8'h00);
        tx_level = 5'd16;

        // R4 / R5 transmit counter
        tx_reload = 16'd3; tx_load = 1'b1; tick(); tx_load = 1'b0;
        chk("R4 tx start", {7'h0, status[2]}, 8'h01);
        tx_dec = 1'b1; tick(2);
        chk("R5 no early finish", {7'h0, status[4]}, 8'h00);
        tick(); tx_dec = 1'b0;
        chk("R5 tx finish", {7'h0, status[4]}, 8'h01);
        // R10 clear sticky
        clear_all();
        chk("R10 cleared", status & 8'hFC, 8'h00);
        // R11 decrement at zero
        tx_dec = 1'b1; tick(2); tx_dec = 1'b0;
        chk("R11 no second finish", {7'h0, status[4]}, 8'h00);
        // R4 / R5 receive counter
        rx_reload = 16'd1; rx_load = 1'b1; tick(); rx_load = 1'b0;
        chk("R4 rx start", {7'h0, status[3]}, 8'h01);
        rx_dec = 1'b1; tick(); rx_dec = 1'b0;
        chk("R5 rx finish", {7'h0, status[5]}, 8'h01);
        // R9 mask on status line
        chk("R9 all masked", {7'h0, irq_status}, 8'h00);
        mask = 8'hDF; #1;
        chk("R9 rx finish unmasked", {7'h0, irq_status}, 8'h01);
        mask = 8'hFF;
        clear_all();

        // R6 mode fault
        master_mode = 1'b1; rx_en = 1'b1; ss_n_in = 1'b0;
        tick(2); chk("R6 sync delay", {7'h0, status[6]}, 8'h00);
        tick();  chk("R6 fault", {7'h0, status[6]}, 8'h01);
        ss_n_in = 1'b1; tick(3); clear_all();
        // R6 slave mode ignores
        master_mode = 1'b0; ss_n_in = 1'b0; tick(4);
        chk("R6 slave none", {7'h0, status[6]}, 8'h00);
        // R8 channels disabled
        master_mode = 1'b1; rx_en = 1'b0; tick(4);
        chk("R8 mf gated", {7'h0, status[6]}, 8'h00);
        ss_n_in = 1'b1; master_mode = 1'b0; tick(3); clear_all();

        // R7 underflow
        tx_level = 5'd0; tx_en = 1'b1;
        xfer_start = 1'b1; tick(); xfer_start = 1'b0;
        chk("R7 underflow", {7'h0, status[7]}, 8'h01);
        // R9 error line
        mask = 8'h7F; #1;
        chk("R9 irq_error", {7'h0, irq_error}, 8'h01);
        mask = 8'hFF; #1;
        chk("R9 err masked", {7'h0, irq_error}, 8'h00);
        clear_all();
        master_mode = 1'b1; tx_initiate = 1'b1;
        xfer_start = 1'b1; tick(); xfer_start = 1'b0;
        chk("R7 master init none", {7'h0, status[7]}, 8'h00);
        master_mode = 1'b0; tx_initiate = 1'b0; tx_en = 1'b0;
        xfer_start = 1'b1; tick(); xfer_start = 1'b0;
        chk("R8 tx disabled none", {7'h0, status[7]}, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule